// File: doc/BRIEF.md
# Byte-Wide Peripheral Configuration Port

This block takes configuration data from a host bus one byte at a time and turns each byte into a serial configuration bit stream. A single output, `busy`, tells the host whether it may write. The host presents a byte on `wr_data` and pulses `wr_stb` for one cycle while `busy` is low. The block then holds `busy` high until all eight bits of that byte have left on `ser_dout`.

There are two ways of shifting, and `mode_sync` picks one at the moment a byte is accepted. In self-timed mode the block makes its own burst of eight clock pulses on `cclk_out`. These pulses clock the bits into the local configuration logic and into any downstream devices. In externally clocked mode a free-running clock on `ext_cclk` is synchronized into the system domain. Each of its rising edges moves the stream on by one bit, and `cclk_out` stays low.

A write strobe that arrives while a byte is still being shifted is dropped. Every dropped strobe is counted in a saturating counter and sets a sticky flag, so the host can find out that it ignored the handshake.

Top module: `cfg_byte_port`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `cclk_out`, `ser_dout`, `ovf_flag` and `ovf_cnt` are all 0.
- R2: A cycle with `wr_stb` high and `busy` low captures `wr_data` and `mode_sync`. `busy` reads 1 from the next cycle on.
- R3: Each byte leaves most significant bit first: bit 7 is presented first and bit 0 last.
- R4: In self-timed mode (`mode_sync` = 0 at capture), `cclk_out` gives exactly eight pulses per byte. Each pulse is low for HALF_CYC cycles and then high for HALF_CYC cycles, and the first low phase starts in the cycle after capture.
- R5: `ser_dout` changes only while `cclk_out` is low, so each bit is stable across the whole high phase of its pulse.
- R6: In self-timed mode `busy` stays high for exactly 2 × 8 × HALF_CYC cycles. It falls in the same cycle that `cclk_out` falls after the eighth pulse.
- R7: In externally clocked mode (`mode_sync` = 1 at capture), each synchronized rising edge of `ext_cclk` advances `ser_dout` by one bit. `busy` falls after the eighth such edge and stays high before it.
- R8: In externally clocked mode `cclk_out` stays low for the whole byte.
- R9: A write strobe while `busy` is high is ignored. The byte being shifted continues unchanged, and no extra byte or clock pulse follows it.
- R10: Each ignored strobe adds one to `ovf_cnt`, which saturates at its all-ones value. It also sets `ovf_flag`, which stays set until reset.
- R11: Edges on `ext_cclk` while the block is idle or shifting in self-timed mode have no effect on `busy`, `cclk_out` or the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sync | input | 1 | 0 = self-timed burst, 1 = external clock; sampled on byte capture |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_data | input | DATA_W | Byte written by the host |
| ext_cclk | input | 1 | External shift clock for externally clocked mode (asynchronous) |
| busy | output | 1 | 1 while a byte is being shifted; the host writes only when 0 |
| cclk_out | output | 1 | Generated configuration clock (self-timed mode only) |
| ser_dout | output | 1 | Serial configuration data, MSB first |
| ovf_flag | output | 1 | Sticky: a write was ignored |
| ovf_cnt | output | OVF_W | Saturating count of ignored writes |

## Verification
Some properties are checked on every cycle. A serial bit stays frozen while `cclk_out` is high. An accepted write raises `busy` on the next cycle. A self-timed job lasts its exact cycle length and contains exactly eight pulses. `cclk_out` stays silent during an externally clocked job. The overflow counter advances only on an ignored strobe and stops at its maximum.

Other behaviour only the directed scenarios can show. These scenarios check that the bits arrive in MSB-first order with the right values. They check that a dropped byte never shows up on the stream and that no pulse follows a byte's end. They also check that stray `ext_cclk` edges outside an externally clocked job change nothing.

// File: rtl/cfgp_pkg.sv
// Shared definitions for the byte-wide configuration port.
// Assumes: one byte is the unit the host writes.
package cfgp_pkg;
    typedef enum logic {
        SHIFT_SELF = 1'b0,
        SHIFT_EXT  = 1'b1
    } shift_mode_e;
endpackage

// File: rtl/cfgp_burst_gen.sv
// Self-timed clock burst generator.
// While run is high it toggles cclk every HALF_CYC system cycles, starting low.
// fall_tick marks the cycle whose closing edge takes cclk from high to low.
// Assumes: run drops on the same edge as the last fall, which clears the state.
module cfgp_burst_gen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cclk,
    output logic fall_tick
);
    localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

    logic [HC_W-1:0] half_cnt;
    logic            phase_end;

    assign phase_end = (half_cnt == HC_LAST);
    assign fall_tick = run & cclk & phase_end;

    // Count out each half period and flip the generated clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            cclk     <= 1'b0;
        end else if (!run) begin
            half_cnt <= '0;
            cclk     <= 1'b0;
        end else if (phase_end) begin
            half_cnt <= '0;
            cclk     <= ~cclk;
        end else begin
            half_cnt <= half_cnt + HC_W'(1);
        end
    end
endmodule

// File: rtl/cfgp_edge_sync.sv
// Synchronizes an asynchronous clock input and flags its rising edges.
// rise is high for one system cycle per low-to-high transition.
// Assumes: STAGES >= 2 and the input stays in each level for more than STAGES+1 cycles.
module cfgp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    // Shift the input through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cfgp_shifter.sv
// Byte holding and shift register with completion tracking.
// load is taken only when idle; shift advances one bit MSB first; busy falls on the last shift.
// Assumes: shift is a single-cycle pulse per bit.
module cfgp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              dout,
    output logic              busy
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;

    // Capture a new byte when idle, otherwise step through its bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            busy    <= 1'b0;
        end else if (load && !busy) begin
            shreg   <= load_data;
            bit_cnt <= '0;
            busy    <= 1'b1;
        end else if (busy && shift) begin
            shreg <= {shreg[DATA_W-2:0], 1'b0};
            if (bit_cnt == BIT_LAST) begin
                busy <= 1'b0;
            end else begin
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end

    assign dout = shreg[DATA_W-1];
endmodule

// File: rtl/cfgp_ovf_cnt.sv
// Saturating counter of ignored writes with a sticky flag.
// Assumes: hit is a single-cycle event; the count stops at all ones.
module cfgp_ovf_cnt #(
    parameter int OVF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    output logic [OVF_W-1:0] cnt,
    output logic             flag
);
    localparam logic [OVF_W-1:0] CNT_MAX = {OVF_W{1'b1}};

    // Record each ignored write, holding at the maximum count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
            if (cnt != CNT_MAX) cnt <= cnt + OVF_W'(1);
        end
    end
endmodule

// File: rtl/cfg_byte_port.sv
// Byte-wide peripheral configuration port (top).
// Accepts host bytes under a busy handshake and serializes them MSB first, either
// with a self-generated burst of eight clock pulses or with an external clock.
// Assumes: ext_cclk is asynchronous and slow against clk; mode_sync is sampled at capture.
module cfg_byte_port #(
    parameter int DATA_W      = 8,
    parameter int HALF_CYC    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int OVF_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sync,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_cclk,
    output logic              busy,
    output logic              cclk_out,
    output logic              ser_dout,
    output logic              ovf_flag,
    output logic [OVF_W-1:0]  ovf_cnt
);
    import cfgp_pkg::*;

    shift_mode_e mode_q;
    logic        accept;
    logic        drop;
    logic        self_run;
    logic        gen_cclk;
    logic        gen_fall;
    logic        ext_rise;
    logic        ext_tick;
    logic        shift_now;

    assign accept = wr_stb & ~busy;
    assign drop   = wr_stb & busy;

    // Latch the shift mode together with each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= SHIFT_SELF;
        else if (accept) mode_q <= shift_mode_e'(mode_sync);
    end

    assign self_run  = busy & (mode_q == SHIFT_SELF);
    assign ext_tick  = busy & (mode_q == SHIFT_EXT) & ext_rise;
    assign shift_now = gen_fall | ext_tick;
    assign cclk_out  = gen_cclk;

    cfgp_burst_gen #(
        .HALF_CYC (HALF_CYC)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (self_run),
        .cclk      (gen_cclk),
        .fall_tick (gen_fall)
    );

    cfgp_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_esync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_cclk),
        .rise     (ext_rise)
    );

    cfgp_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (wr_data),
        .shift     (shift_now),
        .dout      (ser_dout),
        .busy      (busy)
    );

    cfgp_ovf_cnt #(
        .OVF_W (OVF_W)
    ) u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (drop),
        .cnt   (ovf_cnt),
        .flag  (ovf_flag)
    );
endmodule

// File: rtl/cfg_byte_port_chk.sv
// Protocol checker for cfg_byte_port, attached by bind below.
// Tracks the mode, length and pulse count of each job from the ports alone.
module cfg_byte_port_chk #(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 2,
    parameter int OVF_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_sync,
    input logic             wr_stb,
    input logic             busy,
    input logic             cclk_out,
    input logic             ser_dout,
    input logic             ovf_flag,
    input logic [OVF_W-1:0] ovf_cnt
);
    localparam int JOB_CYC = 2 * DATA_W * HALF_CYC;

    logic job_ext;
    logic cclk_prev;
    int   busy_len;
    int   pulse_cnt;

    // Follow each job: its mode, busy length and generated rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_ext   <= 1'b0;
            cclk_prev <= 1'b0;
            busy_len  <= 0;
            pulse_cnt <= 0;
        end else begin
            cclk_prev <= cclk_out;
            if (wr_stb && !busy) begin
                job_ext   <= mode_sync;
                busy_len  <= 0;
                pulse_cnt <= 0;
            end else begin
                if (busy) busy_len <= busy_len + 1;
                if (cclk_out && !cclk_prev) pulse_cnt <= pulse_cnt + 1;
            end
        end
    end

    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !busy) |=> busy); // R2

    AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_out |-> $stable(ser_dout)); // R5

    AST_BURST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !job_ext) |-> (busy_len == JOB_CYC)); // R6

    AST_BURST_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !job_ext) |-> (pulse_cnt == DATA_W)); // R4

    AST_EXT_NO_CCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && job_ext) |-> !cclk_out); // R8

    AST_IDLE_NO_CCLK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cclk_out); // R9

    AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy && (ovf_cnt != {OVF_W{1'b1}})) |=> (ovf_cnt == $past(ovf_cnt) + OVF_W'(1))); // R10

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && busy) |=> $stable(ovf_cnt)); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag || (wr_stb && busy)) |=> ovf_flag); // R10
endmodule

bind cfg_byte_port cfg_byte_port_chk #(
    .DATA_W   (DATA_W),
    .HALF_CYC (HALF_CYC),
    .OVF_W    (OVF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sync (mode_sync),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .cclk_out  (cclk_out),
    .ser_dout  (ser_dout),
    .ovf_flag  (ovf_flag),
    .ovf_cnt   (ovf_cnt)
);

// File: tb/sim_cfg_byte_port.sv
// Directed bench for cfg_byte_port: one task per scenario, each checking its own results.
module sim_cfg_byte_port;
    localparam int DATA_W = 8;
    localparam int HALF   = 2;
    localparam int OVF_W  = 4;
    localparam int OVF_MAX = (1 << OVF_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_sync = 1'b0;
    logic              wr_stb = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              ext_cclk = 1'b0;
    logic              busy;
    logic              cclk_out;
    logic              ser_dout;
    logic              ovf_flag;
    logic [OVF_W-1:0]  ovf_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int ovf_model = 0;

    always #5 clk = ~clk;

    cfg_byte_port #(
        .DATA_W      (DATA_W),
        .HALF_CYC    (HALF),
        .SYNC_STAGES (2),
        .OVF_W       (OVF_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sync (mode_sync),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .ext_cclk  (ext_cclk),
        .busy      (busy),
        .cclk_out  (cclk_out),
        .ser_dout  (ser_dout),
        .ovf_flag  (ovf_flag),
        .ovf_cnt   (ovf_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_drops(input int n);
        ovf_model = (ovf_model + n > OVF_MAX) ? OVF_MAX : ovf_model + n;
    endtask

    task automatic check_ovf();
        check(ovf_cnt == OVF_W'(ovf_model), "R10 ovf_cnt", int'(ovf_cnt), ovf_model);
        check(ovf_flag == (ovf_model != 0), "R10 ovf_flag", int'(ovf_flag), int'(ovf_model != 0));
    endtask

    // Reset scenario: every output must come up cleared (R1).
    task automatic t_reset();
        rst_n = 1'b0; wr_stb = 1'b0; mode_sync = 1'b0; ext_cclk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ovf_model = 0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(cclk_out == 1'b0, "R1 cclk_out", int'(cclk_out), 0);
        check(ser_dout == 1'b0, "R1 ser_dout", int'(ser_dout), 0);
        check(ovf_cnt == '0, "R1 ovf_cnt", int'(ovf_cnt), 0);
        check(ovf_flag == 1'b0, "R1 ovf_flag", int'(ovf_flag), 0);
    endtask

    // Self-timed byte: bit order, pulse shape, busy length, drops and ext_cclk noise.
    task automatic t_self_byte(input logic [DATA_W-1:0] d, input int extra, input bit wiggle);
        logic [DATA_W-1:0] got;
        int pulses, busy_cyc, hi_cyc, guard, left;
        bit prev_c;
        string tag;
        tag = wiggle ? "R11" : "R6";
        @(negedge clk);
        mode_sync = 1'b0; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        check(busy == 1'b1, "R2 busy after write", int'(busy), 1);
        check(cclk_out == 1'b0, "R4 first phase low", int'(cclk_out), 0);
        got = '0; pulses = 0; busy_cyc = 0; hi_cyc = 0; guard = 0; prev_c = 1'b0;
        left = extra;
        while (busy && guard < 1000) begin
            busy_cyc++;
            if (cclk_out) begin
                hi_cyc++;
                if (!prev_c) begin
                    got = {got[DATA_W-2:0], ser_dout};
                    pulses++;
                end else begin
                    check(ser_dout == got[0], "R5 bit held high", int'(ser_dout), int'(got[0]));
                end
            end
            prev_c = cclk_out;
            if (left > 0) begin
                wr_stb = 1'b1; wr_data = ~d; left--;
            end else begin
                wr_stb = 1'b0;
            end
            if (wiggle) ext_cclk = ~ext_cclk;
            @(negedge clk);
            guard++;
        end
        wr_stb = 1'b0; ext_cclk = 1'b0;
        add_drops(extra - left);
        check(got == d, "R3 MSB-first byte", int'(got), int'(d));
        check(pulses == DATA_W, "R4 pulse count", pulses, DATA_W);
        check(hi_cyc == DATA_W * HALF, "R4 high cycles", hi_cyc, DATA_W * HALF);
        check(busy_cyc == 2 * DATA_W * HALF, tag, busy_cyc, 2 * DATA_W * HALF);
        check(cclk_out == 1'b0, "R6 clock low at end", int'(cclk_out), 0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!busy && !cclk_out, "R9 no trailing job", int'({busy, cclk_out}), 0);
        end
        check_ovf();
    endtask

    // Externally clocked byte: one bit per ext_cclk rise, silent cclk_out.
    task automatic t_ext_byte(input logic [DATA_W-1:0] d, input bit drop_mid, input bit idle_noise);
        if (idle_noise) begin
            for (int k = 0; k < 4; k++) begin
                ext_cclk = 1'b1; repeat (4) @(negedge clk);
                ext_cclk = 1'b0; repeat (4) @(negedge clk);
            end
            check(busy == 1'b0, "R11 idle edges", int'(busy), 0);
        end
        @(negedge clk);
        mode_sync = 1'b1; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; mode_sync = 1'b0;
        check(busy == 1'b1, "R2 busy after write", int'(busy), 1);
        for (int i = 0; i < DATA_W; i++) begin
            check(ser_dout == d[DATA_W-1-i], "R7 bit order", int'(ser_dout), int'(d[DATA_W-1-i]));
            check(busy == 1'b1, "R7 busy before last edge", int'(busy), 1);
            if (drop_mid && i == 3) begin
                wr_stb = 1'b1; wr_data = ~d;
                @(negedge clk);
                wr_stb = 1'b0;
                add_drops(1);
                check(ser_dout == d[DATA_W-1-i], "R9 byte unchanged", int'(ser_dout), int'(d[DATA_W-1-i]));
            end
            ext_cclk = 1'b1;
            repeat (4) begin
                @(negedge clk);
                check(cclk_out == 1'b0, "R8 cclk_out silent", int'(cclk_out), 0);
            end
            ext_cclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        check(busy == 1'b0, "R7 busy after eighth edge", int'(busy), 0);
        check_ovf();
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_self_byte(8'hA5, 0, 1'b0);
        t_self_byte(8'h01, 0, 1'b0);
        t_self_byte(8'h80, 3, 1'b0);
        t_self_byte(8'h3C, 0, 1'b1);
        t_ext_byte(8'hC3, 1'b0, 1'b1);
        t_ext_byte(8'h5A, 1'b1, 1'b0);
        for (int r = 0; r < 10; r++) begin
            if (r % 2 == 0) t_self_byte(DATA_W'($urandom), int'($urandom % 3), 1'b0);
            else            t_ext_byte(DATA_W'($urandom), 1'b0, 1'b0);
        end
        t_self_byte(8'hFF, 20, 1'b0);
        check(ovf_cnt == OVF_W'(OVF_MAX), "R10 saturation", int'(ovf_cnt), OVF_MAX);
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule